// File: doc/BRIEF.md
# Transport Stream Sync Lock Detector

The block finds packet framing in a byte stream of fixed-length packets. Each packet opens with a programmable sync token. While the block is hunting, it watches for that token at the packet pitch. It declares lock once a programmed number of consecutive tokens have arrived one packet length apart. While locked, it forwards every byte with start-of-packet and end-of-packet markers, so that the sync byte is always the first byte of each forwarded packet. It tolerates isolated corrupted sync bytes and gives up lock only after a programmed number of consecutive misses.

Inputs are a byte lane with a valid qualifier and four configuration inputs: the token, the packet length, the acquisition count and the loss count. A zero on any of the last three selects its built-in value: 188 bytes, 9 good syncs to lock, and 9 misses to drop. Two status outputs are provided: a live lock indication and a sticky flag that records any loss of lock since reset.

Top module: `ts_sync_lock`

## Requirements
- R1: After reset, `locked`, `out_valid` and `lock_lost` are all low, and the block is hunting.
- R2: A zero on `cfg_pkt_len`, `cfg_lock_cnt` or `cfg_drop_cnt` selects 188 bytes, 9 good syncs and 9 misses respectively. The token is always taken from `cfg_token`.
- R3: While hunting, a token opens a candidate, and that token counts as the first good sync. Each further token at the next expected sync position, one packet length of valid bytes later, adds one to the count. The byte that brings the count to the lock threshold raises `locked`, and that same byte is emitted as the first byte of a packet. With a threshold of 1, the first token locks at once.
- R4: During acquisition, a non-token byte at the expected sync position discards the candidate and its count. The block then hunts again, and the next token starts a fresh count at one.
- R5: No byte is emitted while the block is not locked. This includes the byte that causes loss of lock.
- R6: Each emitted byte appears on `out_data` with `out_valid` one clock after it is accepted, unchanged in value. `out_sop` marks the byte at the sync position. `out_eop` marks the byte at position length-1 of the packet.
- R7: While locked, a wrong byte at the sync position counts as a miss but is still emitted with `out_sop`. A correct token at the sync position clears the miss count.
- R8: Lock is lost on the byte whose miss brings the consecutive miss count to the drop threshold. `lock_lost` then goes high and stays high until reset.
- R9: Cycles with `in_valid` low do not advance the packet position and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Input byte |
| cfg_token | input | 8 | Sync token value |
| cfg_pkt_len | input | LEN_W | Packet length in bytes; 0 selects default |
| cfg_lock_cnt | input | CNT_W | Good syncs needed to lock; 0 selects default |
| cfg_drop_cnt | input | CNT_W | Consecutive misses that drop lock; 0 selects default |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of an emitted packet |
| out_eop | output | 1 | Last byte of an emitted packet |
| locked | output | 1 | Lock status |
| lock_lost | output | 1 | Sticky loss-of-lock flag |

## Verification
Every result of this block is due exactly one clock after the byte that causes it. This holds for the forwarded byte and its markers, for the rise and fall of `locked`, and for `lock_lost`. The bench presents one byte per call, on the falling edge. It samples the outputs one nanosecond after the next rising edge, so each check reads the response to exactly the byte just sent. Idle stretches are sampled the same way, after each rising edge in which valid was low, to confirm that no output appears.

// File: rtl/ts_sync_lock.sv
module ts_sync_lock #(
  parameter int LEN_W    = 8,
  parameter int CNT_W    = 4,
  parameter int DEF_LEN  = 188,
  parameter int DEF_LOCK = 9,
  parameter int DEF_DROP = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [7:0]       cfg_token,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [CNT_W-1:0] cfg_lock_cnt,
  input  logic [CNT_W-1:0] cfg_drop_cnt,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             locked,
  output logic             lock_lost
);
  localparam logic [LEN_W-1:0] DLEN  = LEN_W'(DEF_LEN);
  localparam logic [LEN_W-1:0] MINL  = LEN_W'(2);
  localparam logic [CNT_W-1:0] DLOCK = CNT_W'(DEF_LOCK);
  localparam logic [CNT_W-1:0] DDROP = CNT_W'(DEF_DROP);

  typedef enum logic [1:0] {HUNT, CAND, LOCK} state_t;
  state_t st;

  logic [LEN_W-1:0] phase, len_eff, last_pos, phase_nxt;
  logic [CNT_W-1:0] good, miss, lock_thr, drop_thr;
  logic [CNT_W:0]   good_inc, miss_inc;
  logic             is_tok, at_sync;

  assign len_eff   = (cfg_pkt_len == '0) ? DLEN : ((cfg_pkt_len < MINL) ? MINL : cfg_pkt_len);
  assign lock_thr  = (cfg_lock_cnt == '0) ? DLOCK : cfg_lock_cnt;
  assign drop_thr  = (cfg_drop_cnt == '0) ? DDROP : cfg_drop_cnt;
  assign last_pos  = len_eff - LEN_W'(1);
  assign phase_nxt = (phase >= last_pos) ? '0 : phase + LEN_W'(1);
  assign is_tok    = (in_byte == cfg_token);
  assign at_sync   = (phase == '0);
  assign good_inc  = {1'b0, good} + (CNT_W+1)'(1);
  assign miss_inc  = {1'b0, miss} + (CNT_W+1)'(1);
  assign locked    = (st == LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= HUNT;
      phase     <= '0;
      good      <= '0;
      miss      <= '0;
      lock_lost <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      if (in_valid) begin
        out_data <= in_byte;
        unique case (st)
          HUNT: if (is_tok) begin
            phase <= LEN_W'(1);
            good  <= CNT_W'(1);
            miss  <= '0;
            if (lock_thr <= CNT_W'(1)) begin
              st        <= LOCK;
              out_valid <= 1'b1;
              out_sop   <= 1'b1;
            end else begin
              st <= CAND;
            end
          end
          CAND: begin
            if (at_sync) begin
              if (is_tok) begin
                phase <= LEN_W'(1);
                good  <= good_inc[CNT_W-1:0];
                if (good_inc >= {1'b0, lock_thr}) begin
                  st        <= LOCK;
                  miss      <= '0;
                  out_valid <= 1'b1;
                  out_sop   <= 1'b1;
                end
              end else begin
                st    <= HUNT;
                good  <= '0;
                phase <= '0;
              end
            end else begin
              phase <= phase_nxt;
            end
          end
          LOCK: begin
            if (at_sync && !is_tok && (miss_inc >= {1'b0, drop_thr})) begin
              st        <= HUNT;
              lock_lost <= 1'b1;
              good      <= '0;
              miss      <= '0;
              phase     <= '0;
            end else begin
              if (at_sync) miss <= is_tok ? '0 : miss_inc[CNT_W-1:0];
              phase     <= phase_nxt;
              out_valid <= 1'b1;
              out_sop   <= at_sync;
              out_eop   <= (phase == last_pos);
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end
endmodule

module ts_sync_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop,
  input logic locked,
  input logic lock_lost
);
  p_quiet_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);
  p_sop_at_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (out_valid && out_sop));
  p_markers_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> lock_lost);
  p_lost_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> lock_lost);
  p_idle_no_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

bind ts_sync_lock ts_sync_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sop(out_sop), .out_eop(out_eop), .locked(locked), .lock_lost(lock_lost)
);

// File: tb/tb_ts_sync_lock.sv
module tb_ts_sync_lock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [7:0] cfg_token = 8'h47;
  logic [7:0] cfg_pkt_len = '0;
  logic [3:0] cfg_lock_cnt = '0;
  logic [3:0] cfg_drop_cnt = '0;
  logic out_valid, out_sop, out_eop, locked, lock_lost;
  logic [7:0] out_data;

  int total = 0;
  int fails = 0;
  logic ov, osop, oeop, olk, olost;
  logic [7:0] ob;

  always #2 clk = ~clk;

  ts_sync_lock dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_token(cfg_token), .cfg_pkt_len(cfg_pkt_len), .cfg_lock_cnt(cfg_lock_cnt),
    .cfg_drop_cnt(cfg_drop_cnt), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .locked(locked), .lock_lost(lock_lost)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #1;
    ov = out_valid; ob = out_data; osop = out_sop; oeop = out_eop;
    olk = locked; olost = lock_lost;
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] pay(input int k, input int i);
    return 8'h10 + 8'((k * 7 + i) % 32);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!locked && !out_valid && !lock_lost, "R1 reset state",
        {locked, out_valid, lock_lost}, 0);
  endtask

  task automatic t_acquire_default();
    int emits = 0;
    int eops = 0;
    int bad = 0;
    cfg_token = 8'h47; cfg_pkt_len = '0; cfg_lock_cnt = '0; cfg_drop_cnt = '0;
    for (int i = 0; i < 5; i++) put(8'h33);
    for (int k = 0; k < 8; k++) begin
      put(8'h47);
      if (ov) emits++;
      for (int i = 1; i < 188; i++) begin
        put(pay(k, i));
        if (ov) emits++;
      end
    end
    chk(emits == 0 && !olk, "R5 no output while acquiring", emits, 0);
    chk(!olk, "R2 default lock count 9 not reached after 8", olk, 0);
    put(8'h47);
    chk(ov && osop && olk && ob == 8'h47, "R3 lock on ninth sync", {ov, osop, olk}, 7);
    for (int i = 1; i < 188; i++) begin
      put(pay(9, i));
      if (ov) emits++;
      if (oeop) eops++;
      if (ob != pay(9, i) || osop) bad++;
      if (i == 187) chk(oeop, "R6 eop on byte 187 (default length 188)", oeop, 1);
    end
    chk(emits == 187 && eops == 1 && bad == 0, "R6 forwarded packet", emits * 100 + eops, 18701);
  endtask

  task automatic send_pkt(input logic [7:0] s, input int k, output int sops);
    sops = 0;
    put(s);
    if (ov && osop && olk) sops++;
    for (int i = 1; i < 188; i++) put(pay(k, i));
  endtask

  task automatic t_flywheel();
    int s, acc;
    acc = 0;
    for (int k = 0; k < 8; k++) begin send_pkt(8'h00, k, s); acc += s; end
    chk(olk && acc == 8, "R7 eight misses keep lock and emit sop", acc, 8);
    send_pkt(8'h47, 20, s);
    for (int k = 0; k < 8; k++) begin send_pkt(8'h00, k, s); acc += s; end
    chk(olk && acc == 16, "R7 good sync cleared miss count", acc, 16);
    put(8'h00);
    chk(!olk && olost, "R8 lock lost on ninth miss", {olk, olost}, 1);
    chk(!ov, "R5 dropping byte not emitted", ov, 0);
    acc = 0;
    for (int i = 1; i < 188; i++) begin put(pay(3, i)); if (ov) acc++; end
    chk(acc == 0, "R5 no output after loss", acc, 0);
  endtask

  task automatic seg(input logic [7:0] s);
    put(s);
    for (int i = 1; i < 8; i++) put(pay(1, i));
  endtask

  task automatic t_candidate_reject();
    cfg_token = 8'hB8; cfg_pkt_len = 8'd8; cfg_lock_cnt = 4'd3; cfg_drop_cnt = 4'd2;
    seg(8'hB8);
    seg(8'hB8);
    put(8'h55);
    chk(!olk && !ov, "R4 mismatch rejects candidate", olk, 0);
    for (int i = 1; i < 8; i++) put(pay(1, i));
    seg(8'hB8);
    put(8'hB8);
    chk(!olk, "R4 fresh count after reject", olk, 0);
    for (int i = 1; i < 8; i++) put(pay(1, i));
    put(8'hB8);
    chk(olk && ov && osop, "R3 lock on third sync with threshold 3", olk, 1);
    chk(olost, "R8 lost flag sticky across relock", olost, 1);
  endtask

  task automatic t_gaps();
    int eops = 0;
    int idle_out = 0;
    int at = 0;
    for (int i = 1; i < 8; i++) begin
      repeat (2) begin @(posedge clk); #1; if (out_valid) idle_out++; end
      put(pay(2, i));
      if (oeop) begin eops++; at = i; end
    end
    chk(idle_out == 0, "R9 no output in idle cycles", idle_out, 0);
    chk(eops == 1 && at == 7, "R9 idle cycles do not advance position", at, 7);
  endtask

  task automatic t_thresh_one();
    cfg_drop_cnt = 4'd1;
    put(8'h00);
    chk(!olk && !ov, "R8 drop threshold 1 loses on first miss", olk, 0);
    cfg_lock_cnt = 4'd1;
    put(8'hB8);
    chk(olk && ov && osop && ob == 8'hB8, "R3 lock threshold 1 locks at once", olk, 1);
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire_default();
    t_flywheel();
    t_candidate_reject();
    t_gaps();
    t_thresh_one();
    do_reset();
    chk(!lock_lost && !locked, "R1 reset clears sticky flag", lock_lost, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule